// File: doc/BRIEF.md
# Counted Conditional Loop Branch Unit

This unit resolves counted loop branches. Each accepted request carries an opcode byte, a signed 8-bit displacement, the current count register, the zero flag, an address-size code, an operand-size code and the address of the next sequential instruction. The unit decrements the part of the count selected by the address size. It decides from the new count, and for two of the opcodes from the zero flag, whether the branch is taken. It then produces the next instruction pointer.

Results are registered. They appear one clock after a request is presented with `valid_i` high, and they hold until the next request. The zero flag is only an input, and the unit never writes it back. Fetch redirection and pipeline flushing belong to the consumer of `taken_o` and `next_ip_o`.

Top module: `loop_branch_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `taken_o`, `count_o` and `next_ip_o` are all zero.
- R2: `valid_o` equals `valid_i` of the previous cycle. When `valid_i` was low, `count_o`, `taken_o` and `next_ip_o` keep their values.
- R3: Opcode 0xE2 decrements the count and is taken exactly when the new count (selected width) is nonzero, for either value of `zf_i`.
- R4: Opcode 0xE1 decrements the count and is taken only when the new count is nonzero and `zf_i` is 1.
- R5: Opcode 0xE0 decrements the count and is taken only when the new count is nonzero and `zf_i` is 0.
- R6: Size codes are 2'b00 = 16 bits, 2'b01 = 32 bits, and 2'b10 or 2'b11 = 64 bits. With `addr_size_i` selecting 16 or 32 bits, only those low bits are decremented and tested for zero. The upper bits pass unchanged, and a low field of zero wraps to all ones.
- R7: When taken, `next_ip_o` is `seq_ip_i` plus the sign-extended displacement, truncated to the width selected by `op_size_i` (upper bits zero).
- R8: When not taken, `next_ip_o` equals `seq_ip_i` unmodified.
- R9: Any opcode other than 0xE0, 0xE1, 0xE2 leaves `count_o` equal to `count_i`, is not taken, and gives `next_ip_o` equal to `seq_ip_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present this cycle |
| opcode_i | input | 8 | Loop opcode byte |
| disp_i | input | 8 | Signed branch displacement |
| count_i | input | 64 | Current count register |
| zf_i | input | 1 | Zero flag |
| addr_size_i | input | 2 | Count width select |
| op_size_i | input | 2 | Target width select |
| seq_ip_i | input | 64 | Address of the following instruction |
| valid_o | output | 1 | Result valid |
| count_o | output | 64 | Updated count register |
| taken_o | output | 1 | Branch taken |
| next_ip_o | output | 64 | Next instruction pointer |

## Verification
The bench gives a 16-bit count whose low half is zero and whose upper bits are set. A design that decremented the whole register would borrow into the upper bits, and one that tested the full value would take a branch that must fall through. Targets are pushed across the 16-bit and 32-bit boundaries with negative displacements. This catches a missing sign extension or a missing truncation, which would leave stray upper bits or a target off by 256. Every opcode is run with both zero-flag values, and so is a count that reaches zero. An opcode outside the loop set is sent to confirm that it neither decrements nor redirects.

// File: rtl/loop_pkg.sv
package loop_pkg;
  localparam int XLEN   = 64;
  localparam int DISP_W = 8;
  localparam int NLANE  = 3;

  typedef enum logic [1:0] {
    SZ_16  = 2'b00,
    SZ_32  = 2'b01,
    SZ_64  = 2'b10,
    SZ_RSV = 2'b11
  } size_e;

  localparam logic [7:0] OP_CNT_NZF = 8'hE0;
  localparam logic [7:0] OP_CNT_ZF  = 8'hE1;
  localparam logic [7:0] OP_CNT     = 8'hE2;

  function automatic int lane_bits(int k);
    return 16 << k;
  endfunction

  function automatic int lane_idx(size_e s);
    case (s)
      SZ_16:   return 0;
      SZ_32:   return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/loop_cnt_dec.sv
module loop_cnt_dec
  import loop_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] count_i,
  input  size_e        size_i,
  input  logic         en_i,
  output logic [W-1:0] count_o,
  output logic         nz_o
);
  logic [W-1:0] lane_cnt [NLANE];
  logic         lane_nz  [NLANE];

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam int LW = lane_bits(k);
    logic [LW-1:0] low_dec;
    assign low_dec = count_i[LW-1:0] - LW'(1);
    if (LW < W) begin : g_part
      assign lane_cnt[k] = {count_i[W-1:LW], low_dec};
    end else begin : g_full
      assign lane_cnt[k] = low_dec;
    end
    assign lane_nz[k] = |low_dec;
  end

  always_comb begin
    count_o = en_i ? lane_cnt[lane_idx(size_i)] : count_i;
    nz_o    = lane_nz[lane_idx(size_i)];
  end
endmodule

// File: rtl/loop_cond.sv
module loop_cond
  import loop_pkg::*;
(
  input  logic [7:0] opcode_i,
  input  logic       zf_i,
  input  logic       nz_i,
  output logic       op_ok_o,
  output logic       taken_o
);
  always_comb begin
    op_ok_o = 1'b1;
    taken_o = 1'b0;
    case (opcode_i)
      OP_CNT:     taken_o = nz_i;
      OP_CNT_ZF:  taken_o = nz_i & zf_i;
      OP_CNT_NZF: taken_o = nz_i & ~zf_i;
      default:    op_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/loop_target.sv
module loop_target
  import loop_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int DW = DISP_W
) (
  input  logic [W-1:0]  seq_ip_i,
  input  logic [DW-1:0] disp_i,
  input  size_e         size_i,
  output logic [W-1:0]  target_o
);
  logic [W-1:0] sum;
  logic [W-1:0] lane_tgt [NLANE];

  assign sum = seq_ip_i + {{(W-DW){disp_i[DW-1]}}, disp_i};

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam int LW = lane_bits(k);
    if (LW < W) begin : g_trunc
      assign lane_tgt[k] = {{(W-LW){1'b0}}, sum[LW-1:0]};
    end else begin : g_full
      assign lane_tgt[k] = sum;
    end
  end

  assign target_o = lane_tgt[lane_idx(size_i)];
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import loop_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [7:0]      opcode_i,
  input  logic [7:0]      disp_i,
  input  logic [63:0]     count_i,
  input  logic            zf_i,
  input  logic [1:0]      addr_size_i,
  input  logic [1:0]      op_size_i,
  input  logic [63:0]     seq_ip_i,
  output logic            valid_o,
  output logic [63:0]     count_o,
  output logic            taken_o,
  output logic [63:0]     next_ip_o
);
  logic            op_ok, nz, tk;
  logic [XLEN-1:0] cnt_nx, tgt;

  loop_cond u_cond (
    .opcode_i(opcode_i),
    .zf_i    (zf_i),
    .nz_i    (nz),
    .op_ok_o (op_ok),
    .taken_o (tk)
  );

  loop_cnt_dec #(.W(XLEN)) u_dec (
    .count_i(count_i),
    .size_i (size_e'(addr_size_i)),
    .en_i   (op_ok),
    .count_o(cnt_nx),
    .nz_o   (nz)
  );

  loop_target #(.W(XLEN), .DW(DISP_W)) u_tgt (
    .seq_ip_i(seq_ip_i),
    .disp_i  (disp_i),
    .size_i  (size_e'(op_size_i)),
    .target_o(tgt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      count_o   <= '0;
      taken_o   <= 1'b0;
      next_ip_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        count_o   <= cnt_nx;
        taken_o   <= tk;
        next_ip_o <= tk ? tgt : seq_ip_i;
      end
    end
  end
endmodule

// File: rtl/loop_branch_chk.sv
module loop_branch_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [7:0]  opcode_i,
  input logic [63:0] count_i,
  input logic        zf_i,
  input logic [1:0]  addr_size_i,
  input logic [63:0] seq_ip_i,
  input logic        valid_o,
  input logic [63:0] count_o,
  input logic        taken_o,
  input logic [63:0] next_ip_o
);
  logic known_op;
  assign known_op = opcode_i inside {8'hE0, 8'hE1, 8'hE2};

  always @* begin
    if (rst_ni === 1'b0)
      assert_reset_clear_R1: assert (!valid_o && !taken_o && count_o == '0 && next_ip_o == '0);
  end

  assert_valid_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> ($stable(count_o) && $stable(taken_o) && $stable(next_ip_o)));

  assert_zf_needed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == 8'hE1 && !zf_i) |=> !taken_o);

  assert_zf_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == 8'hE0 && zf_i) |=> !taken_o);

  assert_upper_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_size_i == 2'b00) |=> count_o[63:16] == $past(count_i[63:16]));

  assert_fallthru_ip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (taken_o || next_ip_o == $past(seq_ip_i)));

  assert_bad_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !known_op) |=> (!taken_o && count_o == $past(count_i)));
endmodule

bind loop_branch_unit loop_branch_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .opcode_i   (opcode_i),
  .count_i    (count_i),
  .zf_i       (zf_i),
  .addr_size_i(addr_size_i),
  .seq_ip_i   (seq_ip_i),
  .valid_o    (valid_o),
  .count_o    (count_o),
  .taken_o    (taken_o),
  .next_ip_o  (next_ip_o)
);

// File: tb/tb_loop_branch_unit.sv
module tb_loop_branch_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [7:0]  disp_i = '0;
  logic [63:0] count_i = '0;
  logic        zf_i = 1'b0;
  logic [1:0]  addr_size_i = 2'b10;
  logic [1:0]  op_size_i = 2'b10;
  logic [63:0] seq_ip_i = '0;
  logic        valid_o, taken_o;
  logic [63:0] count_o, next_ip_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  loop_branch_unit dut (.*);

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one request at a falling edge, result is stable at the next falling edge
  task automatic issue(logic [7:0] op, logic [7:0] d, logic [63:0] c, logic z,
                       logic [1:0] as, logic [1:0] os, logic [63:0] ip);
    @(negedge clk_i);
    valid_i = 1'b1; opcode_i = op; disp_i = d; count_i = c; zf_i = z;
    addr_size_i = as; op_size_i = os; seq_ip_i = ip;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic expect_res(string req, logic [63:0] c, logic t, logic [63:0] ip);
    chk(req, "valid", 64'(valid_o), 64'd1);
    chk(req, "count", count_o, c);
    chk(req, "taken", 64'(taken_o), 64'(t));
    chk(req, "next_ip", next_ip_o, ip);
  endtask

  task automatic t_reset();
    chk("R1", "valid", 64'(valid_o), 64'd0);
    chk("R1", "taken", 64'(taken_o), 64'd0);
    chk("R1", "count", count_o, 64'd0);
    chk("R1", "next_ip", next_ip_o, 64'd0);
  endtask

  task automatic t_plain();
    issue(8'hE2, 8'hF0, 64'd5, 1'b0, 2'b10, 2'b10, 64'h1000);
    expect_res("R3", 64'd4, 1'b1, 64'h0FF0);
    issue(8'hE2, 8'hF0, 64'd5, 1'b1, 2'b10, 2'b10, 64'h1000);
    expect_res("R3", 64'd4, 1'b1, 64'h0FF0);
    issue(8'hE2, 8'h10, 64'd1, 1'b1, 2'b10, 2'b10, 64'h2000);
    expect_res("R8", 64'd0, 1'b0, 64'h2000);
  endtask

  task automatic t_zf_set();
    issue(8'hE1, 8'h04, 64'd3, 1'b1, 2'b10, 2'b10, 64'h300);
    expect_res("R4", 64'd2, 1'b1, 64'h304);
    issue(8'hE1, 8'h04, 64'd3, 1'b0, 2'b10, 2'b10, 64'h300);
    expect_res("R4", 64'd2, 1'b0, 64'h300);
    issue(8'hE1, 8'h04, 64'd1, 1'b1, 2'b10, 2'b10, 64'h300);
    expect_res("R4", 64'd0, 1'b0, 64'h300);
  endtask

  task automatic t_zf_clear();
    issue(8'hE0, 8'hFE, 64'd9, 1'b0, 2'b10, 2'b10, 64'h400);
    expect_res("R5", 64'd8, 1'b1, 64'h3FE);
    issue(8'hE0, 8'hFE, 64'd9, 1'b1, 2'b10, 2'b10, 64'h400);
    expect_res("R5", 64'd8, 1'b0, 64'h400);
  endtask

  task automatic t_width();
    issue(8'hE2, 8'h00, 64'hAAAA_BBBB_CCCC_0000, 1'b0, 2'b00, 2'b10, 64'h50);
    expect_res("R6", 64'hAAAA_BBBB_CCCC_FFFF, 1'b1, 64'h50);
    issue(8'hE2, 8'h08, 64'hFFFF_FFFF_FFFF_0001, 1'b0, 2'b00, 2'b10, 64'h50);
    expect_res("R6", 64'hFFFF_FFFF_FFFF_0000, 1'b0, 64'h50);
    issue(8'hE2, 8'h00, 64'h1234_5678_0000_0000, 1'b0, 2'b01, 2'b10, 64'h60);
    expect_res("R6", 64'h1234_5678_FFFF_FFFF, 1'b1, 64'h60);
    issue(8'hE2, 8'h08, 64'h0000_0001_0000_0001, 1'b0, 2'b01, 2'b10, 64'h60);
    expect_res("R6", 64'h0000_0001_0000_0000, 1'b0, 64'h60);
  endtask

  task automatic t_trunc();
    issue(8'hE2, 8'h05, 64'd2, 1'b0, 2'b10, 2'b00, 64'h0000_0000_0001_FFFE);
    expect_res("R7", 64'd1, 1'b1, 64'h0000_0000_0000_0003);
    issue(8'hE2, 8'h80, 64'd2, 1'b0, 2'b10, 2'b01, 64'h0000_0001_0000_0010);
    expect_res("R7", 64'd1, 1'b1, 64'h0000_0000_FFFF_FF90);
    issue(8'hE2, 8'h80, 64'd2, 1'b0, 2'b10, 2'b10, 64'h0000_0000_0000_0010);
    expect_res("R7", 64'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FF90);
  endtask

  task automatic t_bad_op();
    issue(8'hE3, 8'h20, 64'd7, 1'b1, 2'b10, 2'b10, 64'h700);
    expect_res("R9", 64'd7, 1'b0, 64'h700);
    issue(8'h90, 8'h20, 64'd0, 1'b0, 2'b00, 2'b10, 64'h710);
    expect_res("R9", 64'd0, 1'b0, 64'h710);
  endtask

  task automatic t_hold();
    issue(8'hE2, 8'h02, 64'd4, 1'b0, 2'b10, 2'b10, 64'h800);
    expect_res("R2", 64'd3, 1'b1, 64'h802);
    opcode_i = 8'hE2; count_i = 64'd100; seq_ip_i = 64'h900; disp_i = 8'h40;
    @(negedge clk_i);
    chk("R2", "valid idle", 64'(valid_o), 64'd0);
    chk("R2", "count held", count_o, 64'd3);
    chk("R2", "taken held", 64'(taken_o), 64'd1);
    chk("R2", "next_ip held", next_ip_o, 64'h802);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_plain();
    t_zf_set();
    t_zf_clear();
    t_width();
    t_trunc();
    t_bad_op();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule